// File: doc/BRIEF.md
# Coalesced Translation Response Distributor

When several translation requests to the same virtual page are merged into one downstream lookup, only the first member of that group (the leader) is actually translated. This block takes the completed lookup for such a group and turns it back into one response per member. It walks the group's member list in the outstanding table and hands each response to the upstream port that member arrived on. It rebuilds each follower's physical address from the translated page base and the follower's own page offset.

The completion carries the translated address, the page size as a power-of-two exponent, an uncacheable flag and the level at which the lookup hit. The member list is read from an external outstanding table through a combinational read port addressed by group and slot. Members leave one per cycle under a valid/ready handshake on the selected upstream port. In the cycle the final member is handed off, the block raises a clear for the group's virtual page so the table can free the entry. No further completion is taken until that point has passed.

Top module: `xlat_rsp_distributor`

## Requirements
- R1: After reset no upstream valid and no clear are raised, and `cmp_ready` is high.
- R2: The member in slot 0 (the leader) is answered with `cmp_paddr` exactly as received, and `rsp_leader` is high only for it.
- R3: A follower's address has its bits above the page offset taken from `cmp_paddr` and its low `cmp_psz` bits taken from its own virtual address (page mask = 2^cmp_psz - 1), so the page size travels with each completion.
- R4: The completion's uncacheable flag appears on the response of every member of the group.
- R5: The completion's hit level appears on the response of every member of the group.
- R6: At most one bit of `rsp_valid` is high, and it is the bit whose index equals the member's recorded port number `tbl_port`.
- R7: `rsp_cnt_pop` is high for a member whose table prefetch bit `tbl_pf` is 0 and low for a prefetch member.
- R8: Members are answered in slot order 0..`cmp_last`, with at most one handoff per cycle. The first is offered in the cycle after the completion is accepted, and a member whose port is not ready is held unchanged.
- R9: `clr_valid` pulses, with `clr_vpage` equal to the completion's `cmp_vpage`, in exactly the cycle the final member is handed off, and at no other time.
- R10: `cmp_ready` is low while a group is being distributed, so a completion offered then waits; it is high again in the cycle after the clear.
- R11: `cmp_last` holds the member count minus one; a value of 0 yields a lone leader response carrying the clear in its handoff cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completed translation offered |
| cmp_ready | output | 1 | Completion accepted this cycle when valid |
| cmp_grp | input | GRP_W | Outstanding-table group index |
| cmp_last | input | SLOT_W | Member count minus one |
| cmp_vpage | input | VPN_W | Virtual page key of the group |
| cmp_paddr | input | AW | Translated physical address of the leader |
| cmp_psz | input | PSZ_W | Page size exponent (bytes = 2^cmp_psz) |
| cmp_uncache | input | 1 | Translated page is uncacheable |
| cmp_hit_lvl | input | HL_W | Level that supplied the translation |
| tbl_grp | output | GRP_W | Table read group index |
| tbl_slot | output | SLOT_W | Table read member slot |
| tbl_vaddr | input | AW | Virtual address of the addressed member |
| tbl_port | input | PID_W | Upstream port number of the addressed member |
| tbl_pf | input | 1 | Addressed member is a prefetch |
| rsp_valid | output | NPORT | Per-port response valid |
| rsp_ready | input | NPORT | Per-port response ready |
| rsp_paddr | output | AW | Member physical address |
| rsp_uncache | output | 1 | Uncacheable flag for the member |
| rsp_hit_lvl | output | HL_W | Hit level for the member |
| rsp_cnt_pop | output | 1 | Remove this level's request-count entry |
| rsp_leader | output | 1 | Member is the group leader |
| clr_valid | output | 1 | Clear the outstanding entry |
| clr_vpage | output | VPN_W | Virtual page to clear |

## Verification
A completion accepted at a clock edge must show its leader on the matching `rsp_valid` bit in the very next cycle. Each later member is due one cycle after its predecessor's handoff, or later by however many cycles the target port stalls. The clear is due combinationally in the cycle of the final handoff, and `cmp_ready` returns one cycle after it. The reference model builds the expected responses at the moment of acceptance and holds them in order in a queue. It compares the head against the outputs in every cycle, half a period away from the edge and after the ready pattern for that cycle is applied. It pops the head only when the ready of the expected port is high, so stalls and back-to-back offers line up cycle for cycle.

// File: rtl/xlat_dist_pkg.sv
package xlat_dist_pkg;

    typedef enum logic [0:0] {
        DS_IDLE = 1'b0,
        DS_SEND = 1'b1
    } dist_state_e;

endpackage

// File: rtl/xlat_page_merge.sv
module xlat_page_merge #(
    parameter int AW    = 32,
    parameter int PSZ_W = 5
) (
    input  logic [AW-1:0]    base_pa,
    input  logic [AW-1:0]    mem_va,
    input  logic [PSZ_W-1:0] psz,
    input  logic             is_leader,
    output logic [AW-1:0]    out_pa
);
    logic [AW-1:0] off_mask;

    // Offset mask from the page size that came back with the translation.
    assign off_mask = (AW'(1) << psz) - AW'(1);

    always_comb begin
        if (is_leader) begin
            out_pa = base_pa;
        end else begin
            out_pa = (base_pa & ~off_mask) | (mem_va & off_mask);
        end
    end
endmodule

// File: rtl/xlat_port_steer.sv
module xlat_port_steer #(
    parameter int NPORT = 4,
    parameter int PID_W = 2
) (
    input  logic             req,
    input  logic [PID_W-1:0] pid,
    input  logic [NPORT-1:0] rdy,
    output logic [NPORT-1:0] vld,
    output logic             fire
);
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        assign vld[gi] = req && (pid == PID_W'(gi));
    end

    assign fire = |(vld & rdy);
endmodule

// File: rtl/xlat_dist_seq.sv
module xlat_dist_seq
    import xlat_dist_pkg::*;
#(
    parameter int AW     = 32,
    parameter int PSZ_W  = 5,
    parameter int HL_W   = 2,
    parameter int VPN_W  = 20,
    parameter int GRP_W  = 3,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [GRP_W-1:0]  cmp_grp,
    input  logic [SLOT_W-1:0] cmp_last,
    input  logic [VPN_W-1:0]  cmp_vpage,
    input  logic [AW-1:0]     cmp_paddr,
    input  logic [PSZ_W-1:0]  cmp_psz,
    input  logic              cmp_uncache,
    input  logic [HL_W-1:0]   cmp_hit_lvl,
    input  logic              fire,
    output logic              busy,
    output logic [GRP_W-1:0]  cur_grp,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [AW-1:0]     cur_base,
    output logic [PSZ_W-1:0]  cur_psz,
    output logic              cur_unc,
    output logic [HL_W-1:0]   cur_hl,
    output logic              cur_leader,
    output logic              clr_valid,
    output logic [VPN_W-1:0]  clr_vpage
);
    typedef struct packed {
        dist_state_e       state;
        logic [GRP_W-1:0]  grp;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] last;
        logic [AW-1:0]     base;
        logic [PSZ_W-1:0]  psz;
        logic              unc;
        logic [HL_W-1:0]   hl;
        logic [VPN_W-1:0]  vpage;
    } seq_t;

    seq_t seq_d, seq_q;
    logic clr_d;

    always_comb begin
        seq_d = seq_q;
        clr_d = 1'b0;
        case (seq_q.state)
            DS_IDLE: begin
                if (cmp_valid) begin
                    seq_d.state = DS_SEND;
                    seq_d.grp   = cmp_grp;
                    seq_d.slot  = '0;
                    seq_d.last  = cmp_last;
                    seq_d.base  = cmp_paddr;
                    seq_d.psz   = cmp_psz;
                    seq_d.unc   = cmp_uncache;
                    seq_d.hl    = cmp_hit_lvl;
                    seq_d.vpage = cmp_vpage;
                end
            end
            DS_SEND: begin
                if (fire) begin
                    if (seq_q.slot == seq_q.last) begin
                        seq_d.state = DS_IDLE;
                        clr_d       = 1'b1;
                    end else begin
                        seq_d.slot = seq_q.slot + 1'b1;
                    end
                end
            end
            default: seq_d.state = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cmp_ready  = (seq_q.state == DS_IDLE);
    assign busy       = (seq_q.state == DS_SEND);
    assign cur_grp    = seq_q.grp;
    assign cur_slot   = seq_q.slot;
    assign cur_base   = seq_q.base;
    assign cur_psz    = seq_q.psz;
    assign cur_unc    = seq_q.unc;
    assign cur_hl     = seq_q.hl;
    assign cur_leader = (seq_q.slot == '0);
    assign clr_valid  = clr_d;
    assign clr_vpage  = seq_q.vpage;
endmodule

// File: rtl/xlat_rsp_distributor.sv
module xlat_rsp_distributor #(
    parameter int AW     = 32,
    parameter int PSZ_W  = 5,
    parameter int HL_W   = 2,
    parameter int VPN_W  = 20,
    parameter int GRP_W  = 3,
    parameter int MAXM   = 8,
    parameter int NPORT  = 4,
    parameter int SLOT_W = $clog2(MAXM),
    parameter int PID_W  = $clog2(NPORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [GRP_W-1:0]  cmp_grp,
    input  logic [SLOT_W-1:0] cmp_last,
    input  logic [VPN_W-1:0]  cmp_vpage,
    input  logic [AW-1:0]     cmp_paddr,
    input  logic [PSZ_W-1:0]  cmp_psz,
    input  logic              cmp_uncache,
    input  logic [HL_W-1:0]   cmp_hit_lvl,
    output logic [GRP_W-1:0]  tbl_grp,
    output logic [SLOT_W-1:0] tbl_slot,
    input  logic [AW-1:0]     tbl_vaddr,
    input  logic [PID_W-1:0]  tbl_port,
    input  logic              tbl_pf,
    output logic [NPORT-1:0]  rsp_valid,
    input  logic [NPORT-1:0]  rsp_ready,
    output logic [AW-1:0]     rsp_paddr,
    output logic              rsp_uncache,
    output logic [HL_W-1:0]   rsp_hit_lvl,
    output logic              rsp_cnt_pop,
    output logic              rsp_leader,
    output logic              clr_valid,
    output logic [VPN_W-1:0]  clr_vpage
);
    logic             busy;
    logic             fire;
    logic [AW-1:0]    cur_base;
    logic [PSZ_W-1:0] cur_psz;
    logic             cur_leader;

    xlat_dist_seq #(
        .AW(AW), .PSZ_W(PSZ_W), .HL_W(HL_W), .VPN_W(VPN_W),
        .GRP_W(GRP_W), .SLOT_W(SLOT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .cmp_ready  (cmp_ready),
        .cmp_grp    (cmp_grp),
        .cmp_last   (cmp_last),
        .cmp_vpage  (cmp_vpage),
        .cmp_paddr  (cmp_paddr),
        .cmp_psz    (cmp_psz),
        .cmp_uncache(cmp_uncache),
        .cmp_hit_lvl(cmp_hit_lvl),
        .fire       (fire),
        .busy       (busy),
        .cur_grp    (tbl_grp),
        .cur_slot   (tbl_slot),
        .cur_base   (cur_base),
        .cur_psz    (cur_psz),
        .cur_unc    (rsp_uncache),
        .cur_hl     (rsp_hit_lvl),
        .cur_leader (cur_leader),
        .clr_valid  (clr_valid),
        .clr_vpage  (clr_vpage)
    );

    xlat_page_merge #(.AW(AW), .PSZ_W(PSZ_W)) merge_i (
        .base_pa  (cur_base),
        .mem_va   (tbl_vaddr),
        .psz      (cur_psz),
        .is_leader(cur_leader),
        .out_pa   (rsp_paddr)
    );

    xlat_port_steer #(.NPORT(NPORT), .PID_W(PID_W)) steer_i (
        .req (busy),
        .pid (tbl_port),
        .rdy (rsp_ready),
        .vld (rsp_valid),
        .fire(fire)
    );

    assign rsp_cnt_pop = !tbl_pf;
    assign rsp_leader  = cur_leader;

    // R6: a response never targets more than one upstream port.
    assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid));

    // R8: an accepted completion offers its leader on the next cycle.
    assert_start_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_ready) |=> (rsp_valid != '0) && rsp_leader);

    // R8: a stalled member is held unchanged.
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_valid != '0) && !fire) |=>
            ($stable(rsp_valid) && $stable(rsp_paddr) && $stable(rsp_leader)));

    // R9: the clear only accompanies an actual handoff.
    assert_clr_on_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> (fire && (rsp_valid != '0)));

    // R10: intake reopens the cycle after the clear.
    assert_reopen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> cmp_ready);

    // R10: no completion is taken while responses are pending.
    assert_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid != '0) |-> !cmp_ready);
endmodule

// File: tb/xlat_rsp_distributor_tb_top.sv
module xlat_rsp_distributor_tb_top;
    localparam int AW = 32, PSZ_W = 5, HL_W = 2, VPN_W = 20, GRP_W = 3;
    localparam int MAXM = 8, NPORT = 4, SLOT_W = 3, PID_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              cmp_valid = 1'b0;
    logic              cmp_ready;
    logic [GRP_W-1:0]  cmp_grp = '0;
    logic [SLOT_W-1:0] cmp_last = '0;
    logic [VPN_W-1:0]  cmp_vpage = '0;
    logic [AW-1:0]     cmp_paddr = '0;
    logic [PSZ_W-1:0]  cmp_psz = '0;
    logic              cmp_uncache = 1'b0;
    logic [HL_W-1:0]   cmp_hit_lvl = '0;
    logic [GRP_W-1:0]  tbl_grp;
    logic [SLOT_W-1:0] tbl_slot;
    logic [AW-1:0]     tbl_vaddr;
    logic [PID_W-1:0]  tbl_port;
    logic              tbl_pf;
    logic [NPORT-1:0]  rsp_valid;
    logic [NPORT-1:0]  rsp_ready = '1;
    logic [AW-1:0]     rsp_paddr;
    logic              rsp_uncache;
    logic [HL_W-1:0]   rsp_hit_lvl;
    logic              rsp_cnt_pop;
    logic              rsp_leader;
    logic              clr_valid;
    logic [VPN_W-1:0]  clr_vpage;

    // Outstanding-table model: fixed member lists per group.
    logic [AW-1:0]    tb_va   [8][8];
    logic [PID_W-1:0] tb_port [8][8];
    logic             tb_pf   [8][8];

    assign tbl_vaddr = tb_va[tbl_grp][tbl_slot];
    assign tbl_port  = tb_port[tbl_grp][tbl_slot];
    assign tbl_pf    = tb_pf[tbl_grp][tbl_slot];

    xlat_rsp_distributor dut_i (.*);

    typedef struct {
        int          port;
        logic [31:0] pa;
        logic        unc;
        logic [1:0]  hl;
        logic        pop;
        logic        lead;
        logic        last;
        logic [19:0] vpage;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit stall_mode = 1'b0;
    bit run_mon = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model, compared every cycle away from the clock edge.
    always @(negedge clk) begin
        if (run_mon) begin
            cyc++;
            for (int p = 0; p < NPORT; p++)
                rsp_ready[p] <= stall_mode ? (((cyc + 3 * p) % 4) != 0) : 1'b1;
            #1;
            if (exp_q.size() == 0) begin
                chk(rsp_valid == '0, "R8 idle", 32'(rsp_valid), 0);
                chk(!clr_valid, "R9 stray clear", 32'(clr_valid), 0);
                chk(cmp_ready, "R10 ready when idle", 32'(cmp_ready), 1);
            end else begin
                exp_t e;
                bit f;
                e = exp_q[0];
                chk(rsp_valid == NPORT'(1 << e.port), "R6 port", 32'(rsp_valid), 32'(1 << e.port));
                if (e.lead) chk(rsp_paddr == e.pa, "R2 leader addr", rsp_paddr, e.pa);
                else        chk(rsp_paddr == e.pa, "R3 follower addr", rsp_paddr, e.pa);
                chk(rsp_leader == e.lead, "R2 leader flag", 32'(rsp_leader), 32'(e.lead));
                chk(rsp_uncache == e.unc, "R4 uncacheable", 32'(rsp_uncache), 32'(e.unc));
                chk(rsp_hit_lvl == e.hl, "R5 hit level", 32'(rsp_hit_lvl), 32'(e.hl));
                chk(rsp_cnt_pop == e.pop, "R7 count pop", 32'(rsp_cnt_pop), 32'(e.pop));
                chk(!cmp_ready, "R10 closed while busy", 32'(cmp_ready), 0);
                f = rsp_ready[e.port];
                chk(clr_valid == (f && e.last), "R9 clear timing", 32'(clr_valid), 32'(f && e.last));
                if (f && e.last)
                    chk(clr_vpage == e.vpage, "R9 clear page", 32'(clr_vpage), 32'(e.vpage));
                if (f) void'(exp_q.pop_front());
            end
            if (cmp_valid && cmp_ready) begin
                logic [31:0] mask;
                mask = (32'd1 << cmp_psz) - 32'd1;
                for (int s = 0; s <= int'(cmp_last); s++) begin
                    exp_t n;
                    n.port  = int'(tb_port[cmp_grp][s]);
                    n.pa    = (s == 0) ? cmp_paddr
                              : ((cmp_paddr & ~mask) | (tb_va[cmp_grp][s] & mask));
                    n.unc   = cmp_uncache;
                    n.hl    = cmp_hit_lvl;
                    n.pop   = !tb_pf[cmp_grp][s];
                    n.lead  = (s == 0);
                    n.last  = (s == int'(cmp_last));
                    n.vpage = cmp_vpage;
                    exp_q.push_back(n);
                end
            end
        end
    end

    task automatic send(input int g, input int last, input logic [19:0] vp, input logic [31:0] pa,
                        input int psz, input bit unc, input int hl);
        @(negedge clk);
        cmp_valid   = 1'b1;
        cmp_grp     = GRP_W'(g);
        cmp_last    = SLOT_W'(last);
        cmp_vpage   = vp;
        cmp_paddr   = pa;
        cmp_psz     = PSZ_W'(psz);
        cmp_uncache = unc;
        cmp_hit_lvl = HL_W'(hl);
        forever begin
            #1;
            if (cmp_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 cmp_valid = 1'b0;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() != 0 || cmp_valid);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int g = 0; g < 8; g++)
            for (int s = 0; s < 8; s++) begin
                tb_va[g][s]   = 32'h4000_0000 ^ (32'(g) << 24) ^ (32'(s) * 32'h0013_9A57);
                tb_port[g][s] = PID_W'((g + s) % NPORT);
                tb_pf[g][s]   = ((s % 3) == 2);
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(rsp_valid == '0, "R1 reset valid", 32'(rsp_valid), 0);
        chk(!clr_valid, "R1 reset clear", 32'(clr_valid), 0);
        chk(cmp_ready, "R1 reset ready", 32'(cmp_ready), 1);
        run_mon = 1'b1;

        // R11: single-member group
        send(1, 0, 20'h0ABCD, 32'h8765_4321, 12, 1'b0, 1);
        drain();
        // R3 R4 R5 R7: four members, 4 KiB page, uncacheable
        send(2, 3, 20'h01234, 32'h1234_5678, 12, 1'b1, 2);
        drain();
        // R3: full group on a 2 MiB page with port stalls (R8)
        stall_mode = 1'b1;
        send(3, 7, 20'h00F00, 32'hCAFE_B0B0, 21, 1'b0, 3);
        drain();
        // R10: second completion offered while the first is distributing
        send(4, 5, 20'h00444, 32'h0BAD_F00D, 16, 1'b1, 0);
        send(5, 2, 20'h00555, 32'h7777_1111, 14, 1'b0, 1);
        drain();
        stall_mode = 1'b0;
        // back-to-back without stalls
        send(6, 7, 20'h00666, 32'hF0F0_0F0F, 30, 1'b1, 2);
        send(0, 1, 20'h00000, 32'h0000_1FFF, 0, 1'b0, 3);
        drain();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule